// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar date as packed BCD words and advances them once per second. The second is derived from a slow oscillator that reaches the block as a one-cycle enable pulse, `osc_en`, in the system clock domain. The divider either counts a fixed 32768 pulses, for a watch crystal, or counts to a programmable compare value, for any other oscillator rate between 32000 Hz and 4194304 Hz. Software uses a small word-wide register port to program the mode, start the counter and read or load the time and date.

Starting, stopping and freezing the counter all work as request and acknowledge exchanges measured in oscillator pulses. A request bit acts in the system clock domain, and its status bit follows two oscillator pulses later. To load a new time while the counter runs, software sets the freeze request and waits for the freeze status before it writes. It then clears the request, and counting starts again from the loaded values with a fresh second. A sticky flag reports that the counter has never been running since reset, which means the stored time is not valid.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the control word at address 0 reads 0x400: all control bits are 0 and only the never-started flag (bit 10) is set. The time word at address 1 reads 0, the date word at address 2 reads 0x00010100 (day 01, month 01, year 00, weekday 0) and the compare word at address 3 reads 0.
- R2: Control bit 0 (run) and bit 3 (freeze) take effect on the next clock. Their status bits, run status at bit 8 and freeze status at bit 9, take the new value on the second `osc_en` pulse after the write, and they change only on `osc_en` pulses.
- R3: The never-started flag (control bit 10) is set by reset. It clears when run status first reads 1 and stays clear until the next reset.
- R4: When control bit 2 is 1, a second elapses every N+1 counted `osc_en` pulses, where N is the compare word at address 3, bits [21:0]. When bit 2 is 0, a second elapses every 32768 counted pulses. A pulse is counted only while the counter is running.
- R5: Time word layout: seconds BCD at bits [6:0], minutes BCD at [14:8], hours BCD at [21:16] and the PM flag at bit 22. Seconds and minutes roll from 59 to 00 and carry. With control bit 1 at 0 (24-hour mode) hours roll from 23 to 00 and advance the date.
- R6: With control bit 1 at 1 (12-hour mode) hours run 12, 01 … 11. The step from 11 to 12 toggles PM, and the step from 11 PM to 12 AM advances the date.
- R7: Date word layout: weekday binary 0–6 at bits [2:0], day BCD at [13:8], month BCD at [20:16] and year BCD at [31:24]. The day rolls over after day 31, 30 or 28, or after 29 in February of a year divisible by 4 (00 counts as a leap year). Month rolls from 12 to 01 and carries into the year, the year rolls from 99 to 00, and the weekday steps 6 to 0.
- R8: While the freeze request is 1 the time and date do not advance. The partial second is discarded, so after release the first advance comes a full second of pulses later.
- R9: Writes to the time or date word take effect only while freeze status is 1 or run status is 0. Otherwise they are ignored.
- R10: Control bits 1 and 2 and the compare word can be written only while run status is 0. Bits 0 and 3 are always writable.
- R11: Counting requires both the run bit and the run status. Once run is cleared, no second elapses even while run status still reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-cycle pulse per slow oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 time, 2 date, 3 compare |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr`, combinational |

## Verification
The bench loads states that sit one second before a carry chain and checks the result after exactly the expected number of pulses. These include the end of a century, the last day of February in both leap and common years, 30-day months and the three 12-hour transitions. A wrong month-length table, a missed leap rule, or a PM flag that toggles at 12 instead of at 11 would leave a wrong date or hour in the read-back word. Randomly drawn states biased toward rollover values cover both hour modes. Other checks catch a counter that keeps a partial second across a freeze, that accepts time, mode or compare writes while running, or that keeps counting between clearing run and the status drop: each shows up as a time or register value off from the expected one.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    typedef struct packed {
        logic       pm;
        logic [5:0] hr;
        logic [6:0] mn;
        logic [6:0] sc;
    } clk_time_t;

    typedef struct packed {
        logic [7:0] yr;
        logic [4:0] mo;
        logic [5:0] dy;
        logic [2:0] wd;
    } clk_date_t;

    localparam logic [2:0] LAST_WDAY = 3'd6;

    localparam int unsigned REG_CTRL = 0;
    localparam int unsigned REG_TIME = 1;
    localparam int unsigned REG_DATE = 2;
    localparam int unsigned REG_CMP  = 3;

    function automatic logic [31:0] time_to_word(clk_time_t t);
        return {9'b0, t.pm, t.hr, 1'b0, t.mn, 1'b0, t.sc};
    endfunction

    function automatic clk_time_t word_to_time(logic [31:0] w);
        clk_time_t t;
        t.pm = w[22];
        t.hr = w[21:16];
        t.mn = w[14:8];
        t.sc = w[6:0];
        return t;
    endfunction

    function automatic logic [31:0] date_to_word(clk_date_t d);
        return {d.yr, 3'b0, d.mo, 2'b0, d.dy, 5'b0, d.wd};
    endfunction

    function automatic clk_date_t word_to_date(logic [31:0] w);
        clk_date_t d;
        d.yr = w[31:24];
        d.mo = w[20:16];
        d.dy = w[13:8];
        d.wd = w[2:0];
        return d;
    endfunction

    // Add one to a two-digit BCD value (no wrap beyond the tens digit).
    function automatic logic [7:0] bcd_inc(logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

    function automatic logic [6:0] bcd_to_bin(logic [7:0] v);
        return ({3'b0, v[7:4]} * 7'd10) + {3'b0, v[3:0]};
    endfunction

    // Last valid day of a month, BCD encoded.
    function automatic logic [5:0] month_last(logic [4:0] mo, logic [7:0] yr);
        logic [6:0] ybin;
        ybin = bcd_to_bin(yr);
        case (mo)
            5'h02:                      return (ybin[1:0] == 2'b00) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_lag_sync.sv
module rtc_lag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_en,
    input  logic req,
    output logic stat
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)         sh_q <= '0;
                else if (osc_en) sh_q <= req;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)         sh_q <= '0;
                else if (osc_en) sh_q <= {sh_q[STAGES-2:0], req};
            end
        end
    endgenerate

    assign stat = sh_q[STAGES-1];

    // R2: status moves only on oscillator pulses
    assert_stat_on_osc_R2: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> $stable(stat));

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_en,
    input  logic             count_en,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !count_en)
            cnt_q <= '0;
        else if (osc_en)
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
    end

    assign tick = count_en && osc_en && (cnt_q == limit);

    // R4: the running count never passes the programmed limit
    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        count_en |-> (cnt_q <= limit));

    // R8: a stopped divider restarts from zero
    assert_cnt_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        !count_en |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_bcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  logic      h12,
    input  logic      wr_time,
    input  logic      wr_date,
    input  clk_time_t time_in,
    input  clk_date_t date_in,
    output clk_time_t time_q,
    output clk_date_t date_q
);
    clk_time_t nt;
    clk_date_t nd;
    logic      day_c;

    always_comb begin
        nt    = time_q;
        nd    = date_q;
        day_c = 1'b0;
        if (time_q.sc == 7'h59) begin
            nt.sc = '0;
            if (time_q.mn == 7'h59) begin
                nt.mn = '0;
                if (h12) begin
                    if (time_q.hr == 6'h12) begin
                        nt.hr = 6'h01;
                    end else if (time_q.hr == 6'h11) begin
                        nt.hr = 6'h12;
                        nt.pm = ~time_q.pm;
                        day_c = time_q.pm;
                    end else begin
                        nt.hr = 6'(bcd_inc({2'b0, time_q.hr}));
                    end
                end else begin
                    if (time_q.hr == 6'h23) begin
                        nt.hr = '0;
                        day_c = 1'b1;
                    end else begin
                        nt.hr = 6'(bcd_inc({2'b0, time_q.hr}));
                    end
                end
            end else begin
                nt.mn = 7'(bcd_inc({1'b0, time_q.mn}));
            end
        end else begin
            nt.sc = 7'(bcd_inc({1'b0, time_q.sc}));
        end

        if (day_c) begin
            nd.wd = (date_q.wd >= LAST_WDAY) ? 3'd0 : date_q.wd + 3'd1;
            if (date_q.dy == month_last(date_q.mo, date_q.yr)) begin
                nd.dy = 6'h01;
                if (date_q.mo == 5'h12) begin
                    nd.mo = 5'h01;
                    nd.yr = (date_q.yr == 8'h99) ? 8'h00 : bcd_inc(date_q.yr);
                end else begin
                    nd.mo = 5'(bcd_inc({3'b0, date_q.mo}));
                end
            end else begin
                nd.dy = 6'(bcd_inc({2'b0, date_q.dy}));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= '0;
            date_q <= '{yr: 8'h00, mo: 5'h01, dy: 6'h01, wd: 3'd0};
        end else begin
            if (wr_time)  time_q <= time_in;
            else if (adv) time_q <= nt;
            if (wr_date)  date_q <= date_in;
            else if (adv) date_q <= nd;
        end
    end

    // R5: seconds wrap to zero
    assert_sec_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_time && time_q.sc == 7'h59) |=> (time_q.sc == 7'h00));

    // R7: December rolls into January
    assert_month_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_date && day_c && date_q.mo == 5'h12 &&
         date_q.dy == month_last(date_q.mo, date_q.yr)) |=> (date_q.mo == 5'h01));

    // R8: without an advance or a write the time is held
    assert_time_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!adv && !wr_time) |=> $stable(time_q));

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_bcd_pkg::*;
#(
    parameter int PRESC_W     = 22,
    parameter int XTAL_DIV    = 32768,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_en,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    localparam logic [PRESC_W-1:0] XTAL_LIMIT = PRESC_W'(XTAL_DIV - 1);

    logic               run_q, frz_q, h12_q, csel_q, stopped_q;
    logic [PRESC_W-1:0] cmp_q;
    logic               run_stat, frz_stat;
    logic               count_en, tick, wr_ok;
    logic               wr_ctrl, wr_time, wr_date, wr_cmp;
    logic [PRESC_W-1:0] limit;
    clk_time_t          time_q;
    clk_date_t          date_q;

    assign wr_ctrl  = wr_en && (addr == 2'(REG_CTRL));
    assign wr_time  = wr_en && (addr == 2'(REG_TIME));
    assign wr_date  = wr_en && (addr == 2'(REG_DATE));
    assign wr_cmp   = wr_en && (addr == 2'(REG_CMP));
    assign wr_ok    = frz_stat || !run_stat;
    assign count_en = run_q && run_stat && !frz_q;
    assign limit    = csel_q ? cmp_q : XTAL_LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            frz_q  <= 1'b0;
            h12_q  <= 1'b0;
            csel_q <= 1'b0;
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q <= wdata[0];
                frz_q <= wdata[3];
                if (!run_stat) begin
                    h12_q  <= wdata[1];
                    csel_q <= wdata[2];
                end
            end
            if (wr_cmp && !run_stat)
                cmp_q <= wdata[PRESC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           stopped_q <= 1'b1;
        else if (run_stat) stopped_q <= 1'b0;
    end

    rtc_lag_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
        .clk(clk), .rst(rst), .osc_en(osc_en), .req(run_q), .stat(run_stat)
    );

    rtc_lag_sync #(.STAGES(SYNC_STAGES)) u_frz_sync (
        .clk(clk), .rst(rst), .osc_en(osc_en), .req(frz_q), .stat(frz_stat)
    );

    rtc_prescaler #(.CNT_W(PRESC_W)) u_presc (
        .clk(clk), .rst(rst), .osc_en(osc_en), .count_en(count_en),
        .limit(limit), .tick(tick)
    );

    rtc_time_core u_core (
        .clk(clk), .rst(rst), .adv(tick), .h12(h12_q),
        .wr_time(wr_time && wr_ok), .wr_date(wr_date && wr_ok),
        .time_in(word_to_time(wdata)), .date_in(word_to_date(wdata)),
        .time_q(time_q), .date_q(date_q)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            2'(REG_CTRL): begin
                rdata[0]  = run_q;
                rdata[1]  = h12_q;
                rdata[2]  = csel_q;
                rdata[3]  = frz_q;
                rdata[8]  = run_stat;
                rdata[9]  = frz_stat;
                rdata[10] = stopped_q;
            end
            2'(REG_TIME): rdata = time_to_word(time_q);
            2'(REG_DATE): rdata = date_to_word(date_q);
            default:      rdata = {{(32-PRESC_W){1'b0}}, cmp_q};
        endcase
    end

    // R3: once cleared, the never-started flag stays clear
    assert_stopped_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        !stopped_q |=> !stopped_q);

    // R10: mode and compare are locked while running
    assert_mode_locked_R10: assert property (@(posedge clk) disable iff (rst)
        run_stat |=> ($stable(h12_q) && $stable(csel_q) && $stable(cmp_q)));

    // R9: a blocked time write leaves the time unchanged
    assert_time_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_time && !wr_ok && !tick) |=> $stable(time_q));

    // R11: no second elapses unless the run bit is set
    assert_no_tick_idle_R11: assert property (@(posedge clk) disable iff (rst)
        tick |-> (run_q && run_stat));

endmodule

// File: tb/tb_rtc_bcd_calendar.sv
`timescale 1ns/1ps
module tb_rtc_bcd_calendar;

    typedef struct {
        int sc, mn, hr, pm, wd, dy, mo, yr;
    } st_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rtc_bcd_calendar dut (
        .clk(clk), .rst(rst), .osc_en(osc_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic int to_bcd(int n);
        return ((n / 10) << 4) | (n % 10);
    endfunction

    function automatic logic [31:0] time_word(st_t s);
        return 32'((s.pm << 22) | (to_bcd(s.hr) << 16) | (to_bcd(s.mn) << 8) | to_bcd(s.sc));
    endfunction

    function automatic logic [31:0] date_word(st_t s);
        return 32'((to_bcd(s.yr) << 24) | (to_bcd(s.mo) << 16) | (to_bcd(s.dy) << 8) | s.wd);
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic st_t step(st_t s, bit h12);
        st_t n = s;
        bit day = 0;
        n.sc++;
        if (n.sc == 60) begin
            n.sc = 0; n.mn++;
            if (n.mn == 60) begin
                n.mn = 0;
                if (h12) begin
                    if (s.hr == 12) n.hr = 1;
                    else if (s.hr == 11) begin n.hr = 12; n.pm = 1 - s.pm; day = (s.pm == 1); end
                    else n.hr = s.hr + 1;
                end else begin
                    if (s.hr == 23) begin n.hr = 0; day = 1; end
                    else n.hr = s.hr + 1;
                end
            end
        end
        if (day) begin
            n.wd = (s.wd + 1) % 7;
            n.dy = s.dy + 1;
            if (n.dy > mdays(s.mo, s.yr)) begin
                n.dy = 1; n.mo = s.mo + 1;
                if (n.mo == 13) begin n.mo = 1; n.yr = (s.yr + 1) % 100; end
            end
        end
        return n;
    endfunction

    function automatic st_t mk(int hr, int mn, int sc, int pm, int wd, int dy, int mo, int yr);
        st_t s;
        s.hr = hr; s.mn = mn; s.sc = sc; s.pm = pm; s.wd = wd; s.dy = dy; s.mo = mo; s.yr = yr;
        return s;
    endfunction

    function automatic st_t rand_state(bit h12);
        st_t s;
        s.sc = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
        s.mn = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
        if (h12) begin
            s.hr = ($urandom % 2 == 0) ? 11 + int'($urandom % 2) : 1 + int'($urandom % 12);
            s.pm = int'($urandom % 2);
        end else begin
            s.hr = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
            s.pm = 0;
        end
        s.yr = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
        s.mo = ($urandom % 3 == 0) ? 2 + 10 * int'($urandom % 2) : 1 + int'($urandom % 12);
        s.dy = ($urandom % 2 == 0) ? mdays(s.mo, s.yr) : 1 + int'($urandom % mdays(s.mo, s.yr));
        s.wd = int'($urandom % 7);
        return s;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        addr = 2'(a);
        #1;
        d = rdata;
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_en = 1'b1;
            @(negedge clk); osc_en = 1'b0;
        end
    endtask

    task automatic chk_state(string tag, st_t s);
        logic [31:0] v;
        rd(1, v); chk({tag, " time"}, v, time_word(s));
        rd(2, v); chk({tag, " date"}, v, date_word(s));
    endtask

    // Freeze, load a state, release, let secs seconds pass (compare 3 -> 4 pulses each).
    task automatic run_case(string tag, logic [31:0] base, st_t s, bit h12, int secs);
        st_t e = s;
        wr(0, base | 32'h8);
        pulse(2);
        wr(1, time_word(s));
        wr(2, date_word(s));
        wr(0, base);
        pulse(4 * secs);
        for (int i = 0; i < secs; i++) e = step(e, h12);
        chk_state(tag, e);
    endtask

    task automatic start_run(logic [31:0] mode);
        wr(0, mode);
        wr(0, mode | 32'h1);
        pulse(2);
    endtask

    task automatic stop_run(logic [31:0] mode);
        wr(0, mode);
        pulse(2);
    endtask

    initial begin
        logic [31:0] v;
        st_t s;
        void'($urandom(32'd2024));

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(0, v); chk("R1 ctrl", v, 32'h400);
        rd(1, v); chk("R1 time", v, 32'h0);
        rd(2, v); chk("R1 date", v, 32'h00010100);
        rd(3, v); chk("R1 cmp", v, 32'h0);

        // R10 mode and compare writable while idle
        wr(3, 32'd3);
        rd(3, v); chk("R10 cmp idle", v, 32'd3);
        wr(0, 32'h6);
        rd(0, v); chk("R10 mode idle", v, 32'h406);
        wr(0, 32'h4);

        // R9 load while idle
        s = mk(23, 59, 58, 0, 6, 31, 12, 99);
        wr(1, time_word(s));
        wr(2, date_word(s));
        chk_state("R9 idle load", s);

        // R2 / R3 start-up
        wr(0, 32'h5);
        pulse(1);
        rd(0, v); chk("R2 run status lag", v, 32'h405);
        pulse(1);
        rd(0, v); chk("R2 R3 run status up", v, 32'h105);

        // R4 / R5 / R7 counting across the century
        pulse(3);
        chk_state("R4 partial second", s);
        pulse(1);
        s = step(s, 0);
        chk_state("R4 one second", s);
        pulse(4);
        s = step(s, 0);
        chk_state("R5 R7 century wrap", s);

        // R10 locked while running
        wr(3, 32'd9);
        rd(3, v); chk("R10 cmp locked", v, 32'd3);
        wr(0, 32'h7);
        rd(0, v); chk("R10 mode locked", v & 32'hF, 32'h5);
        wr(0, 32'h5);

        // R9 blocked write while running
        wr(1, time_word(mk(5, 5, 5, 0, 0, 1, 1, 0)));
        rd(1, v); chk("R9 blocked time", v, time_word(s));

        // R8 freeze discards partial second
        pulse(2);
        wr(0, 32'hD);
        pulse(2);
        rd(0, v); chk("R2 freeze status", v & 32'h200, 32'h200);
        pulse(8);
        chk_state("R8 frozen", s);
        s = mk(10, 20, 30, 0, 2, 15, 6, 45);
        wr(1, time_word(s));
        wr(2, date_word(s));
        wr(0, 32'h5);
        pulse(3);
        chk_state("R8 fresh second", s);
        pulse(1);
        s = step(s, 0);
        chk_state("R8 resumed", s);

        // R11 run cleared, status still high
        wr(0, 32'h4);
        pulse(1);
        rd(0, v); chk("R2 R11 status still 1", v, 32'h104);
        pulse(8);
        chk_state("R11 no count", s);
        rd(0, v); chk("R2 R3 status down", v, 32'h004);

        // 24-hour directed corners and random
        start_run(32'h4);
        run_case("R7 feb common", 32'h5, mk(23, 59, 59, 0, 1, 28, 2, 23), 0, 1);
        run_case("R7 feb leap", 32'h5, mk(23, 59, 59, 0, 1, 28, 2, 24), 0, 1);
        run_case("R7 feb 29", 32'h5, mk(23, 59, 59, 0, 2, 29, 2, 0), 0, 1);
        run_case("R7 april end", 32'h5, mk(23, 59, 59, 0, 4, 30, 4, 50), 0, 1);
        run_case("R7 weekday wrap", 32'h5, mk(23, 59, 59, 0, 6, 15, 6, 10), 0, 1);
        run_case("R5 minute carry", 32'h5, mk(12, 34, 59, 0, 3, 9, 9, 9), 0, 2);
        for (int i = 0; i < 30; i++)
            run_case("R5 R7 random 24h", 32'h5, rand_state(0), 0, 1 + int'($urandom % 3));
        stop_run(32'h4);

        // 12-hour directed corners and random
        start_run(32'h6);
        run_case("R6 noon", 32'h7, mk(11, 59, 59, 0, 0, 5, 5, 5), 1, 1);
        run_case("R6 one pm", 32'h7, mk(12, 59, 59, 1, 0, 5, 5, 5), 1, 1);
        run_case("R6 midnight", 32'h7, mk(11, 59, 59, 1, 3, 31, 1, 7), 1, 1);
        run_case("R6 twelve am", 32'h7, mk(12, 59, 59, 0, 3, 1, 2, 7), 1, 1);
        for (int i = 0; i < 30; i++)
            run_case("R6 R7 random 12h", 32'h7, rand_state(1), 1, 1 + int'($urandom % 3));
        stop_run(32'h6);

        // R4 crystal divider
        wr(0, 32'h0);
        rd(0, v); chk("R10 crystal mode", v & 32'hF, 32'h0);
        s = mk(8, 0, 0, 0, 4, 20, 3, 30);
        wr(1, time_word(s));
        wr(2, date_word(s));
        wr(0, 32'h1);
        pulse(2);
        @(negedge clk); osc_en = 1'b1;
        repeat (32767) @(negedge clk);
        osc_en = 1'b0;
        chk_state("R4 crystal 32767", s);
        pulse(1);
        s = step(s, 0);
        chk_state("R4 crystal 32768", s);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule